// File: doc/BRIEF.md
# Serial Flash Transfer Timing Sequencer

This block runs complete transfers to serial flash or EEPROM devices on a four-wire serial bus, across two independently selected memory banks. A transfer request names the bank, whether it is a read or a write, the opcode to use for writes, a 24-bit address and a data byte count. The sequencer builds the byte stream itself. It sends the opcode first and then the address. Fast reads also get a dummy byte. The data phase follows. For a write the data bytes are pulled one at a time from a data input. For a read the returned bytes are handed out one at a time.

Timing on the serial bus comes from a set of configuration inputs:
- a clock divider for the serial clock;
- a per-bank address width;
- a gap between bytes during which the serial clock is frozen while the bank stays selected;
- a minimum time during which every bank must stay deselected between transfers.

The configuration is captured only when a request is accepted. Software may therefore rewrite it while a transfer is in flight without disturbing that transfer.

Top module: `sflash_seq`

## Requirements
- R1: Out of reset and while no transfer is running, both chip selects are high (inactive), sck_o is low, busy_o is 0, req_ready_o is 1 and done_o is 0.
- R2: A normal read (cfg_fast_i = 0) sends opcode 0x03, then the address bytes, then one 0x00 byte per data byte. Each data byte is returned on rdata_o with a one-cycle rdata_valid_o pulse, in order.
- R3: Bit b of cfg_alen2_i selects the address width of bank b. A value of 0 sends req_addr_i[23:16], [15:8] and [7:0]. A value of 1 sends only [15:8] and [7:0].
- R4: A fast read (cfg_fast_i = 1) sends opcode 0x0B, then the address, then one dummy 0x00 byte before the data bytes. The byte received during the dummy byte is not returned on rdata_o.
- R5: A write sends req_opcode_i, then the address, then req_len_i bytes taken from wdata_i. A one-cycle wdata_take_o pulse marks each edge at which wdata_i is consumed. The first data byte is taken at the end of the last address byte.
- R6: sck_o idles low. Each half period lasts cfg_presc_i+1 system clocks, and the first rising edge comes one half period after selection. Bits go out MSB first: mosi_o changes only on falling edges or at selection, and miso_i is sampled on rising edges.
- R7: Between consecutive bytes of a transfer, sck_o stays low for an extra 2*cfg_hold_i half periods while the chip select stays low.
- R8: After the last byte, every chip select stays high for at least 2*(cfg_tcs_i+1) half periods, using the transfer's own divider. busy_o falls exactly when that interval ends.
- R9: cfg_alen2_i, cfg_hold_i, cfg_fast_i, cfg_presc_i and cfg_tcs_i are captured when a request is accepted. Changes made while busy_o is high take effect only for the next transfer.
- R10: A request is accepted when req_valid_i and req_ready_o are both high. req_ready_o is low while busy_o is high. done_o pulses for one cycle on the edge that releases the chip select after the last byte, and busy_o is still high during that pulse.
- R11: Only the chip select of the requested bank goes low: cs_no[b] belongs to bank b, and at most one chip select is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_alen2_i | input | 2 | Per-bank address width, 1 = two address bytes |
| cfg_hold_i | input | 8 | Clock-stopped serial periods between bytes |
| cfg_fast_i | input | 1 | Fast read select |
| cfg_presc_i | input | 7 | Serial clock divider, half period = value+1 clocks |
| cfg_tcs_i | input | 4 | Deselect interval, value+1 serial periods |
| req_valid_i | input | 1 | Transfer request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_bank_i | input | 1 | Bank index of the request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_opcode_i | input | 8 | Opcode used for writes |
| req_addr_i | input | 24 | Memory address |
| req_len_i | input | 8 | Number of data bytes |
| wdata_i | input | 8 | Write data byte to be taken next |
| wdata_take_o | output | 1 | wdata_i is consumed at this edge |
| rdata_o | output | 8 | Received read data byte |
| rdata_valid_o | output | 1 | rdata_o holds a new byte |
| busy_o | output | 1 | Transfer or deselect interval in progress |
| done_o | output | 1 | Pulse when the last byte completes |
| sck_o | output | 1 | Serial clock |
| cs_no | output | 2 | Chip selects, active low, bit per bank |
| mosi_o | output | 1 | Serial data to memory |
| miso_i | input | 1 | Serial data from memory |

## Verification
The assertions assume that reset is applied before the first request, and that wdata_i already holds the next byte whenever the engine may take one. Beyond that they rely only on the sequencer's own outputs, so any sequence of requests and configuration values is legal. The bench keeps the configuration steady from request until acceptance, and always pre-loads the write byte before it can be taken. It changes the divider, hold and deselect settings only after acceptance, which exercises the capture rule. A behavioral memory responder returns a byte pattern that depends on position, which makes a dropped or extra dummy byte visible.

// File: rtl/sflash_pkg.sv
package sflash_pkg;
  localparam int unsigned NBANK   = 2;
  localparam int unsigned BANK_W  = $clog2(NBANK);
  localparam int unsigned PRESC_W = 7;
  localparam int unsigned HOLD_W  = 8;
  localparam int unsigned TCS_W   = 4;
  localparam int unsigned LEN_W   = 8;
  localparam int unsigned ADDR_W  = 24;
  localparam int unsigned IDX_W   = LEN_W + 1;   // opcode + 3 addr + dummy + data
  localparam int unsigned GAP_W   = HOLD_W + 2;

  localparam logic [7:0] OP_RD_NORM = 8'h03;
  localparam logic [7:0] OP_RD_FAST = 8'h0B;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_HOLD, ST_DESEL} seq_st_e;

  typedef struct packed {
    logic [NBANK-1:0]   alen2;
    logic [HOLD_W-1:0]  hold;
    logic [PRESC_W-1:0] presc;
    logic [TCS_W-1:0]   tcs;
  } seq_cfg_t;
endpackage

// File: rtl/sflash_tick.sv
module sflash_tick #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sflash_gap.sv
module sflash_gap #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  assign expire_o = tick_i && (cnt_q == W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/sflash_byte_sel.sv
module sflash_byte_sel
  import sflash_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [IDX_W-1:0]  hdr_i,
  input  logic              alen2_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        byte_o,
  output logic              data_o
);
  logic [ADDR_W-1:0] aligned;

  always_comb begin
    aligned = alen2_i ? {addr_i[15:0], 8'h00} : addr_i;
    data_o  = (idx_i >= hdr_i);
    byte_o  = 8'h00;                          // dummy and read-phase filler
    if (data_o) begin
      if (write_i) byte_o = wdata_i;
    end else if (idx_i == IDX_W'(1)) begin
      byte_o = aligned[23:16];
    end else if (idx_i == IDX_W'(2)) begin
      byte_o = aligned[15:8];
    end else if (idx_i == IDX_W'(3) && !alen2_i) begin
      byte_o = aligned[7:0];
    end
  end
endmodule

// File: rtl/sflash_seq.sv
module sflash_seq
  import sflash_pkg::*;
#(
  parameter logic [TCS_W-1:0] TCS_RST = 4'd5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NBANK-1:0]   cfg_alen2_i,
  input  logic [HOLD_W-1:0]  cfg_hold_i,
  input  logic               cfg_fast_i,
  input  logic [PRESC_W-1:0] cfg_presc_i,
  input  logic [TCS_W-1:0]   cfg_tcs_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [BANK_W-1:0]  req_bank_i,
  input  logic               req_write_i,
  input  logic [7:0]         req_opcode_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [LEN_W-1:0]   req_len_i,
  input  logic [7:0]         wdata_i,
  output logic               wdata_take_o,
  output logic [7:0]         rdata_o,
  output logic               rdata_valid_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               sck_o,
  output logic [NBANK-1:0]   cs_no,
  output logic               mosi_o,
  input  logic               miso_i
);
  seq_st_e           st_q;
  seq_cfg_t          cfg_q;
  logic [BANK_W-1:0] bank_q;
  logic              write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic              sck_q;
  logic [NBANK-1:0]  cs_q;
  logic [7:0]        sh_q, rx_q, rdata_q;
  logic [2:0]        bit_q;
  logic [IDX_W-1:0]  idx_q, hdr_q;
  logic              rvalid_q, done_q;

  logic              tick, gap_exp, gap_load;
  logic [GAP_W-1:0]  gap_val, tcs_p1;
  logic              accept, byte_end, is_last, nxt_data;
  logic [IDX_W-1:0]  nxt_idx, last_idx, new_hdr;
  logic [7:0]        nxt_byte, op0;

  assign accept   = (st_q == ST_IDLE) && req_valid_i;
  assign byte_end = (st_q == ST_SHIFT) && tick && sck_q && (bit_q == 3'd7);
  assign nxt_idx  = idx_q + IDX_W'(1);
  assign last_idx = hdr_q + IDX_W'(len_q) - IDX_W'(1);
  assign is_last  = (idx_q == last_idx);
  assign new_hdr  = IDX_W'(1) + (cfg_alen2_i[req_bank_i] ? IDX_W'(2) : IDX_W'(3))
                  + IDX_W'(cfg_fast_i && !req_write_i);
  assign op0      = req_write_i ? req_opcode_i : (cfg_fast_i ? OP_RD_FAST : OP_RD_NORM);

  assign tcs_p1   = GAP_W'(cfg_q.tcs) + GAP_W'(1);
  assign gap_load = byte_end && (is_last || cfg_q.hold != '0);
  assign gap_val  = is_last ? {tcs_p1[GAP_W-2:0], 1'b0} : {GAP_W'(cfg_q.hold) << 1};

  sflash_tick #(.W(PRESC_W)) u_tick (
    .clk_i, .rst_ni, .run_i(st_q != ST_IDLE), .div_i(cfg_q.presc), .tick_o(tick)
  );

  sflash_gap #(.W(GAP_W)) u_gap (
    .clk_i, .rst_ni, .load_i(gap_load), .load_val_i(gap_val), .tick_i(tick),
    .expire_o(gap_exp)
  );

  sflash_byte_sel u_sel (
    .idx_i(nxt_idx), .hdr_i(hdr_q), .alen2_i(cfg_q.alen2[bank_q]), .addr_i(addr_q),
    .write_i(write_q), .wdata_i, .byte_o(nxt_byte), .data_o(nxt_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cfg_q    <= '{alen2: '0, hold: '0, presc: '0, tcs: TCS_RST};
      bank_q   <= '0;
      write_q  <= 1'b0;
      addr_q   <= '0;
      len_q    <= '0;
      sck_q    <= 1'b0;
      cs_q     <= '1;
      sh_q     <= '0;
      rx_q     <= '0;
      rdata_q  <= '0;
      bit_q    <= '0;
      idx_q    <= '0;
      hdr_q    <= '0;
      rvalid_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      done_q   <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          st_q    <= ST_SHIFT;
          cfg_q   <= '{alen2: cfg_alen2_i, hold: cfg_hold_i, presc: cfg_presc_i, tcs: cfg_tcs_i};
          bank_q  <= req_bank_i;
          write_q <= req_write_i;
          addr_q  <= req_addr_i;
          len_q   <= req_len_i;
          hdr_q   <= new_hdr;
          idx_q   <= '0;
          bit_q   <= '0;
          sck_q   <= 1'b0;
          sh_q    <= op0;
          cs_q    <= ~(NBANK'(1) << req_bank_i);
        end
        ST_SHIFT: if (tick) begin
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx_q  <= {rx_q[6:0], miso_i};
          end else begin
            sck_q <= 1'b0;
            if (bit_q != 3'd7) begin
              bit_q <= bit_q + 3'd1;
              sh_q  <= {sh_q[6:0], 1'b0};
            end else begin
              bit_q <= '0;
              if (idx_q >= hdr_q && !write_q) begin
                rdata_q  <= rx_q;
                rvalid_q <= 1'b1;
              end
              if (is_last) begin
                cs_q   <= '1;
                done_q <= 1'b1;
                st_q   <= ST_DESEL;
              end else begin
                idx_q <= nxt_idx;
                sh_q  <= nxt_byte;
                if (cfg_q.hold != '0) st_q <= ST_HOLD;
              end
            end
          end
        end
        ST_HOLD:  if (gap_exp) st_q <= ST_SHIFT;
        ST_DESEL: if (gap_exp) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o   = (st_q == ST_IDLE);
  assign busy_o        = (st_q != ST_IDLE);
  assign wdata_take_o  = byte_end && !is_last && nxt_data && write_q;
  assign rdata_o       = rdata_q;
  assign rdata_valid_o = rvalid_q;
  assign done_o        = done_q;
  assign sck_o         = sck_q;
  assign cs_no         = cs_q;
  assign mosi_o        = sh_q[7];
endmodule

// File: rtl/sflash_seq_chk.sv
module sflash_seq_chk
  import sflash_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             rdata_valid_o,
  input logic             wdata_take_o,
  input logic             sck_o,
  input logic [NBANK-1:0] cs_no,
  input logic             mosi_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cs_no) |-> !sck_o);

  assert_one_bank_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));

  assert_mosi_steady_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));

  assert_accept_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (busy_o && !req_ready_o && !(&cs_no)));

  assert_done_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((&cs_no) && busy_o));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_rdata_in_xfer_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |-> busy_o);

  assert_take_selected_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdata_take_o |-> (busy_o && !(&cs_no)));
endmodule

bind sflash_seq sflash_seq_chk u_chk (.*);

// File: tb/tb_sflash_seq.sv
module tb_sflash_seq;
  import sflash_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [1:0] cfg_alen2 = '0;
  logic [7:0] cfg_hold = '0;
  logic       cfg_fast = 1'b0;
  logic [6:0] cfg_presc = '0;
  logic [3:0] cfg_tcs = 4'd5;
  logic       req_valid = 1'b0, req_bank = 1'b0, req_write = 1'b0;
  logic [7:0] req_opcode = '0, req_len = '0, wdata = '0;
  logic [23:0] req_addr = '0;
  logic        ready, take, rvalid, busy, done, sck, mosi, miso = 1'b0;
  logic [7:0]  rdata;
  logic [1:0]  cs_n;
  wire         cs_act = ~&cs_n;

  sflash_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_alen2_i(cfg_alen2), .cfg_hold_i(cfg_hold),
    .cfg_fast_i(cfg_fast), .cfg_presc_i(cfg_presc), .cfg_tcs_i(cfg_tcs),
    .req_valid_i(req_valid), .req_ready_o(ready), .req_bank_i(req_bank),
    .req_write_i(req_write), .req_opcode_i(req_opcode), .req_addr_i(req_addr),
    .req_len_i(req_len), .wdata_i(wdata), .wdata_take_o(take), .rdata_o(rdata),
    .rdata_valid_o(rvalid), .busy_o(busy), .done_o(done), .sck_o(sck), .cs_no(cs_n),
    .mosi_o(mosi), .miso_i(miso)
  );

  int n_chk = 0, n_bad = 0, n_done = 0;
  logic [7:0] exp_mosi[$], exp_rd[$], wq[$];
  int q_p[$], q_h[$], q_tcs[$], q_bank[$];
  bit q_b2b[$];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] resp(input int j);
    logic [7:0] r;
    r = 8'h5A + 8'(j * 37);
    return r;
  endfunction

  task automatic refresh_wdata();
    wdata = (wq.size() != 0) ? wq[0] : 8'h00;
  endtask

  // driver: pushes expectations, then hands the request over
  task automatic xfer(input int bank, input bit wr, input logic [7:0] op,
                      input logic [23:0] addr, input int len, input bit b2b);
    bit a2, dm;
    int hdr;
    a2  = cfg_alen2[bank];
    dm  = cfg_fast && !wr;
    hdr = 1 + (a2 ? 2 : 3) + int'(dm);
    q_p.push_back(int'(cfg_presc) + 1);
    q_h.push_back(int'(cfg_hold));
    q_tcs.push_back(int'(cfg_tcs));
    q_bank.push_back(bank);
    q_b2b.push_back(b2b);
    exp_mosi.push_back(wr ? op : (cfg_fast ? 8'h0B : 8'h03));
    if (!a2) exp_mosi.push_back(addr[23:16]);
    exp_mosi.push_back(addr[15:8]);
    exp_mosi.push_back(addr[7:0]);
    if (dm) exp_mosi.push_back(8'h00);
    for (int k = 0; k < len; k++) begin
      if (wr) begin
        exp_mosi.push_back(8'hC0 + 8'(k) + 8'(bank * 16));
        wq.push_back(8'hC0 + 8'(k) + 8'(bank * 16));
      end else begin
        exp_mosi.push_back(8'h00);
        exp_rd.push_back(resp(hdr + k));
      end
    end
    refresh_wdata();
    @(negedge clk);
    req_bank = bank[0]; req_write = wr; req_opcode = op; req_addr = addr;
    req_len = 8'(len); req_valid = 1'b1;
    while (!ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int p, input int tcs);
    int n;
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(busy && !ready, "R10 busy high and ready low at done", int'(busy), 1);
    n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    chk(n == 2 * (tcs + 1) * p, "R8 busy time after done", n, 2 * (tcs + 1) * p);
  endtask

  // memory responder: collects mosi bytes, drives miso pattern
  logic [7:0] rsh;
  int bitn = 0, byten = 0;
  always @(posedge cs_act) begin
    logic [7:0] r;
    bitn = 0; byten = 0;
    r = resp(0);
    miso = r[7];
  end
  always @(posedge sck) if (cs_act) begin
    rsh = {rsh[6:0], mosi};
    bitn++;
    if (bitn == 8) begin
      if (exp_mosi.size() == 0) chk(1'b0, "R2 R3 R4 R5 unexpected mosi byte", int'(rsh), -1);
      else begin
        logic [7:0] e;
        e = exp_mosi.pop_front();
        chk(rsh == e, "R2 R3 R4 R5 mosi byte", int'(rsh), int'(e));
      end
      bitn = 0;
      byten++;
    end
  end
  always @(negedge sck) if (cs_act) begin
    logic [7:0] r;
    r = resp(byten);
    miso = r[7 - bitn];
  end

  // scoreboard monitor for read data
  always @(negedge clk) if (rst_n && rvalid) begin
    if (exp_rd.size() == 0) chk(1'b0, "R2 R4 unexpected read byte", int'(rdata), -1);
    else begin
      logic [7:0] e;
      e = exp_rd.pop_front();
      chk(rdata == e, "R2 R4 read data", int'(rdata), int'(e));
    end
  end

  always @(negedge clk) if (rst_n && done) n_done++;

  always @(negedge clk) if (rst_n && take) begin
    @(posedge clk);
    #1;
    if (wq.size() != 0) void'(wq.pop_front());
    refresh_wdata();
  end

  // serial timing monitor
  bit prev_act = 0, prev_sck = 0, have_prev = 0;
  int lowc, highc, gapc, rises, tbad, cp, ch, ctcs, prev_n;
  always @(negedge clk) if (rst_n) begin
    if (cs_act && !prev_act) begin
      int bk;
      bit bb;
      cp = q_p.pop_front(); ch = q_h.pop_front(); ctcs = q_tcs.pop_front();
      bk = q_bank.pop_front(); bb = q_b2b.pop_front();
      chk(cs_n == ~(2'(1) << bk), "R11 selected bank", int'(cs_n), int'(~(2'(1) << bk)));
      if (have_prev) begin
        chk(gapc >= prev_n, "R8 deselect gap", gapc, prev_n);
        if (bb) chk(gapc <= prev_n + 2, "R8 back-to-back gap", gapc, prev_n + 1);
      end
      lowc = 1; rises = 0; tbad = 0;
    end else if (cs_act) begin
      if (sck && !prev_sck) begin
        int e;
        e = (rises == 0) ? cp : ((rises % 8 == 0) ? (2 * ch + 1) * cp : cp);
        if (lowc != e) tbad++;
        rises++;
        highc = 1;
      end else if (sck) highc++;
      else if (prev_sck) begin
        if (highc != cp) tbad++;
        lowc = 1;
      end else lowc++;
    end else if (prev_act) begin
      chk(tbad == 0, "R6 R7 R9 sck phase lengths", tbad, 0);
      gapc = 1;
      prev_n = 2 * (ctcs + 1) * cp;
      have_prev = 1;
    end else gapc++;
    prev_act = cs_act;
    prev_sck = sck;
  end

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 2'b11 && !sck, "R1 reset bus idle", int'({cs_n, sck}), 6);
    chk(!busy && ready && !done, "R1 reset handshake", int'({busy, ready, done}), 2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n == 2'b11 && ready, "R1 idle after reset", int'({cs_n, ready}), 7);

    // normal read, 3-byte address, fastest divider
    xfer(0, 0, 8'h00, 24'h123456, 3, 0);
    wait_done(1, 5);

    // bank 1 with 2-byte address, hold gaps
    cfg_alen2 = 2'b10; cfg_hold = 8'd2; cfg_presc = 7'd1;
    xfer(1, 0, 8'h00, 24'hABCDEF, 2, 0);
    wait_done(2, 5);

    // fast read with dummy byte
    cfg_fast = 1'b1; cfg_presc = 7'd2; cfg_hold = 8'd0;
    xfer(0, 0, 8'h00, 24'h010203, 2, 0);
    wait_done(3, 5);

    // write on bank 1, 3-byte address
    cfg_fast = 1'b0; cfg_alen2 = 2'b00; cfg_hold = 8'd1; cfg_presc = 7'd0;
    xfer(1, 1, 8'h02, 24'h0F0E0D, 3, 0);
    wait_done(1, 5);

    // config changed mid-transfer, then a queued request
    cfg_tcs = 4'd2; cfg_presc = 7'd1; cfg_hold = 8'd0;
    xfer(0, 0, 8'h00, 24'h778899, 2, 0);
    cfg_presc = 7'd3; cfg_tcs = 4'd0; cfg_hold = 8'd1; cfg_alen2 = 2'b01;
    xfer(0, 1, 8'h32, 24'h00A5C3, 2, 1);
    wait_done(4, 0);

    repeat (5) @(negedge clk);
    chk(exp_mosi.size() == 0, "R2 R5 all mosi bytes seen", exp_mosi.size(), 0);
    chk(exp_rd.size() == 0, "R2 all read bytes returned", exp_rd.size(), 0);
    chk(wq.size() == 0, "R5 all write bytes taken", wq.size(), 0);
    chk(n_done == 6, "R10 one done per transfer", n_done, 6);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule